// File: doc/BRIEF.md
# Programmable Interval Timer Counter Array

The block is a host-programmed timer peripheral holding three independent 16-bit down counters behind an 8-bit parallel bus. Each counter has its own count clock, gate input and output pin. The host sees four byte ports chosen by a 2-bit address: ports 0, 1 and 2 are the counters' data ports and port 3 takes control words. A control word either configures one counter (byte order for loading and reading, counting mode, binary or decimal arithmetic) or freezes a snapshot of its running value so the host can read it safely while the count clock keeps going.

The count clocks and gates are external, slow signals. Inside, they are brought into the system clock domain and turned into edge events. The gate level is taken on each rising count-clock edge. The counters load and decrement on each falling count-clock edge. Two counting modes are provided. The first is a one-shot terminal-count flag. The second is a periodic rate generator that emits a one-period low pulse.

Top module: `pit_timer_array`

## Requirements
- R1: After reset, all three `cnt_out` pins are high and `rdata_oe` is low.
- R2: A write to port 3 is a control word. Bits [7:6] select the counter (0, 1 or 2); the value 3 is ignored and changes no counter. Bits [5:4] hold the byte format. Bits [3:1] hold the mode: a value with [2:1] = 10 selects the rate generator, and every other value selects the terminal-count mode. Bit [0] = 1 selects decimal (BCD) counting.
- R3: A read strobe at port 3 leaves the bus undriven (`rdata_oe` = 0). A read strobe at ports 0 to 2 drives it.
- R4: While `cs_n` is high, bus writes and reads have no effect, and the counters keep counting on their count clocks.
- R5: Byte format 01 moves only the low byte and loads zero into the high byte. Format 10 moves only the high byte and loads zero into the low byte. Format 11 moves the low byte and then the high byte, with a per-counter toggle for writes and another for reads.
- R6: Byte format 00 is a latch command. It captures the counter's value, and reads return that captured value until it has been fully read. A second latch command issued while a capture is still unread is ignored.
- R7: Without a latch command, a read returns the live count while counting continues.
- R8: In terminal-count mode, `cnt_out` goes low on the control write and on any count write. The new count is loaded on the next falling count-clock edge after the last byte. The count then decrements on each falling edge, and `cnt_out` goes high when the count reaches 0.
- R9: In terminal-count mode, a gate sampled low on a rising count-clock edge holds the count unchanged.
- R10: In rate-generator mode, `cnt_out` is high after the control write. It goes low for exactly one count-clock period when the count reaches 1, then goes high as the count reloads, so a loaded value N gives a period of N clocks.
- R11: With BCD selected, each of the four digits counts down 9 to 0 with a borrow into the next digit. A decrement from 1000 gives 0999, and an initial count of 0 gives 9999 after one decrement, which is 10000 counts.
- R12: In binary, an initial count of 0 gives FFFF after one decrement, which is 65536 counts.
- R13: Counting edges on one counter's clock change no other counter's value or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe, one clock per byte |
| wr_n | input | 1 | Active-low write strobe, one clock per byte |
| addr | input | 2 | Port select: 0 to 2 are counters, 3 is control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | High while the block drives `rdata` |
| cnt_clk | input | 3 | Count clock per counter |
| cnt_gate | input | 3 | Gate per counter |
| cnt_out | output | 3 | Output per counter |

## Verification
The bench targets the following corner cases:
- **Snapshot freeze.** It latches a counter, keeps clocking it, and issues a second latch. A design that re-captured on the second latch, or released the snapshot after only the first byte, would return a later value.
- **Zero initial counts.** It loads 0 in binary and in BCD. A design without a digit-wise borrow would show 0xFFFF instead of 9999.
- **Rate-generator pulse.** It times the low pulse edge by edge. A design that reloaded one clock late, or held the output low for two clocks, would miscompare in the pulse phase.
- **Deselected access and reserved selector.** It writes while deselected and sends a control word with the reserved selector. Either would otherwise reconfigure a counter that is still running, and the running value would then read back stale.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    FMT_LATCH = 2'b00,
    FMT_LO    = 2'b01,
    FMT_HI    = 2'b10,
    FMT_WORD  = 2'b11
  } fmt_e;

  typedef enum logic {
    MD_TERM = 1'b0,
    MD_RATE = 1'b1
  } mode_e;

  typedef struct packed {
    fmt_e  fmt;
    mode_e mode;
    logic  bcd;
  } cfg_t;

endpackage

// File: rtl/pit_sync_edge.sv
module pit_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
  assign fall  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pit_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_CNT-1:0]  cfg_we,
  output logic [NUM_CNT-1:0]  latch_cmd,
  output logic [NUM_CNT-1:0]  data_we,
  output logic [NUM_CNT-1:0]  data_rd,
  output cfg_t                cfg_word
);
  localparam int SEL_HI  = DATA_W - 1;
  localparam int FMT_HI_B = DATA_W - ADDR_W - 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CNT);

  logic               wr_act, rd_act, ctrl_hit;
  logic [ADDR_W-1:0]  sel;
  logic [2:0]         mode_raw;

  always_comb begin
    wr_act   = !cs_n && !wr_n;
    rd_act   = !cs_n && !rd_n;
    ctrl_hit = (addr == CTRL_ADDR);
    sel      = wdata[SEL_HI -: ADDR_W];
    mode_raw = wdata[3:1];
    cfg_word.fmt  = fmt_e'(wdata[FMT_HI_B -: 2]);
    cfg_word.mode = (mode_raw[1:0] == 2'b10) ? MD_RATE : MD_TERM;
    cfg_word.bcd  = wdata[0];
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    always_comb begin
      cfg_we[i]    = wr_act && ctrl_hit && (sel == ADDR_W'(i)) && (cfg_word.fmt != FMT_LATCH);
      latch_cmd[i] = wr_act && ctrl_hit && (sel == ADDR_W'(i)) && (cfg_word.fmt == FMT_LATCH);
      data_we[i]   = wr_act && (addr == ADDR_W'(i));
      data_rd[i]   = rd_act && (addr == ADDR_W'(i));
    end
  end

  // R4: deselected cycles must reach no counter
  a_r4_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (cfg_we == '0 && latch_cmd == '0 && data_we == '0 && data_rd == '0));

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              latch_cmd,
  input  logic              data_we,
  input  logic              data_rd,
  input  cfg_t              cfg_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              gate_lvl,
  output logic [DATA_W-1:0] rdata,
  output logic              out
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int DIGITS = CNT_W / 4;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  cfg_t             cfg_q, cfg_d;
  logic [CNT_W-1:0] cr_q, cr_d, ce_q, ce_d, ol_q, ol_d, dec_val, src;
  logic             latched_q, latched_d, wr_hi_q, wr_hi_d, rd_hi_q, rd_hi_d;
  logic             pend_q, pend_d, armed_q, armed_d, gate_q, gate_d, out_q, out_d;

  function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic             borrow;
    r = v;
    borrow = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (r[d*4 +: 4] == 4'd0) begin
          r[d*4 +: 4] = 4'd9;
        end else begin
          r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  always_comb begin
    dec_val = cfg_q.bcd ? bcd_dec(ce_q) : (ce_q - ONE);
    src     = latched_q ? ol_q : ce_q;
    case (cfg_q.fmt)
      FMT_LO:   rdata = src[DATA_W-1:0];
      FMT_HI:   rdata = src[CNT_W-1:DATA_W];
      FMT_WORD: rdata = rd_hi_q ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
      default:  rdata = '0;
    endcase
  end

  always_comb begin
    cfg_d = cfg_q;  cr_d = cr_q;  ce_d = ce_q;  ol_d = ol_q;
    latched_d = latched_q;  wr_hi_d = wr_hi_q;  rd_hi_d = rd_hi_q;
    pend_d = pend_q;  armed_d = armed_q;  gate_d = gate_q;  out_d = out_q;

    if (tick_rise) gate_d = gate_lvl;

    if (tick_fall) begin
      if (pend_q) begin
        ce_d    = cr_q;
        pend_d  = 1'b0;
        armed_d = 1'b1;
        if (cfg_q.mode == MD_RATE) out_d = 1'b1;
      end else if (armed_q) begin
        if (cfg_q.mode == MD_TERM) begin
          if (gate_q) begin
            ce_d = dec_val;
            if (ce_q == ONE) out_d = 1'b1;
          end
        end else begin
          if (!gate_q) begin
            out_d = 1'b1;
          end else if (ce_q == TWO) begin
            ce_d  = dec_val;
            out_d = 1'b0;
          end else if (ce_q == ONE) begin
            ce_d  = cr_q;
            out_d = 1'b1;
          end else begin
            ce_d = dec_val;
          end
        end
      end
    end

    if (latch_cmd && !latched_q) begin
      ol_d      = ce_q;
      latched_d = 1'b1;
    end

    if (data_rd) begin
      if (cfg_q.fmt == FMT_WORD) begin
        rd_hi_d = !rd_hi_q;
        if (rd_hi_q) latched_d = 1'b0;
      end else begin
        latched_d = 1'b0;
      end
    end

    if (data_we) begin
      if (cfg_q.mode == MD_TERM) out_d = 1'b0;
      case (cfg_q.fmt)
        FMT_LO: begin
          cr_d   = {{DATA_W{1'b0}}, wdata};
          pend_d = 1'b1;
        end
        FMT_HI: begin
          cr_d   = {wdata, {DATA_W{1'b0}}};
          pend_d = 1'b1;
        end
        FMT_WORD: begin
          if (!wr_hi_q) begin
            cr_d[DATA_W-1:0] = wdata;
            wr_hi_d = 1'b1;
            if (cfg_q.mode == MD_TERM) armed_d = 1'b0;
          end else begin
            cr_d[CNT_W-1:DATA_W] = wdata;
            wr_hi_d = 1'b0;
            pend_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (cfg_we) begin
      cfg_d     = cfg_word;
      armed_d   = 1'b0;
      pend_d    = 1'b0;
      wr_hi_d   = 1'b0;
      rd_hi_d   = 1'b0;
      latched_d = 1'b0;
      out_d     = (cfg_word.mode == MD_RATE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{fmt: FMT_WORD, mode: MD_TERM, bcd: 1'b0};
      cr_q      <= '0;
      ce_q      <= '0;
      ol_q      <= '0;
      latched_q <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      pend_q    <= 1'b0;
      armed_q   <= 1'b0;
      gate_q    <= 1'b0;
      out_q     <= 1'b1;
    end else begin
      cfg_q     <= cfg_d;
      cr_q      <= cr_d;
      ce_q      <= ce_d;
      ol_q      <= ol_d;
      latched_q <= latched_d;
      wr_hi_q   <= wr_hi_d;
      rd_hi_q   <= rd_hi_d;
      pend_q    <= pend_d;
      armed_q   <= armed_d;
      gate_q    <= gate_d;
      out_q     <= out_d;
    end
  end

  assign out = out_q;

  // R9: low gate freezes a running terminal-count counter
  a_r9_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MD_TERM && armed_q && !pend_q && !gate_q && !cfg_we && !data_we)
      |=> $stable(ce_q));

  // R8: terminal-count output only rises once the count is zero
  a_r8_out_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_q) && cfg_q.mode == MD_TERM) |-> (ce_q == '0));

  // R10: rate-generator low pulse ends at the next counting edge
  a_r10_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MD_RATE && !out_q && tick_fall && !cfg_we && !data_we) |=> out_q);

  // R12: binary decrement by one per falling edge
  a_r12_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MD_TERM && !cfg_q.bcd && armed_q && !pend_q && gate_q && tick_fall
     && !cfg_we && !data_we) |=> (ce_q == $past(ce_q) - ONE));

  // R6: a pending snapshot stays frozen until read out or reconfigured
  a_r6_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !cfg_we && !data_rd) |=> $stable(ol_q));

endmodule

// File: rtl/pit_timer_array.sv
module pit_timer_array
  import pit_pkg::*;
#(
  parameter int NUM_CNT     = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_CNT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               rdata_oe,
  input  logic [NUM_CNT-1:0] cnt_clk,
  input  logic [NUM_CNT-1:0] cnt_gate,
  output logic [NUM_CNT-1:0] cnt_out
);
  logic [NUM_CNT-1:0] cfg_we, latch_cmd, data_we, data_rd;
  logic [NUM_CNT-1:0] tk_rise, tk_fall, gate_lvl;
  logic [DATA_W-1:0]  cnt_rdata [NUM_CNT];
  cfg_t               cfg_word;

  pit_bus_decode #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .cfg_we(cfg_we), .latch_cmd(latch_cmd),
    .data_we(data_we), .data_rd(data_rd), .cfg_word(cfg_word)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic clk_lvl_unused, gate_rise_unused, gate_fall_unused;

    pit_sync_edge #(.STAGES(SYNC_STAGES)) u_clk_sync (
      .clk(clk), .rst_n(rst_n), .din(cnt_clk[i]),
      .level(clk_lvl_unused), .rise(tk_rise[i]), .fall(tk_fall[i])
    );

    pit_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .din(cnt_gate[i]),
      .level(gate_lvl[i]), .rise(gate_rise_unused), .fall(gate_fall_unused)
    );

    pit_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[i]), .latch_cmd(latch_cmd[i]),
      .data_we(data_we[i]), .data_rd(data_rd[i]), .cfg_word(cfg_word),
      .wdata(wdata), .tick_rise(tk_rise[i]), .tick_fall(tk_fall[i]),
      .gate_lvl(gate_lvl[i]), .rdata(cnt_rdata[i]), .out(cnt_out[i])
    );
  end

  always_comb begin
    rdata    = '0;
    rdata_oe = 1'b0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (!cs_n && !rd_n && addr == ADDR_W'(i)) begin
        rdata    = cnt_rdata[i];
        rdata_oe = 1'b1;
      end
    end
  end

  // R3: a read of the control port never drives the bus
  a_r3_ctrl_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr == ADDR_W'(NUM_CNT)) |-> !rdata_oe);

  // R4: with chip select high the bus is never driven
  a_r4_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !rdata_oe);

endmodule

// File: tb/tb_pit_timer_array.sv
module tb_pit_timer_array;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [2:0] cnt_clk = '0;
  logic [2:0] cnt_gate = 3'b111;
  logic [2:0] cnt_out;

  int       n_checks = 0;
  int       n_fail = 0;
  bit       done = 1'b0;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;

  pit_timer_array dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .cnt_clk(cnt_clk), .cnt_gate(cnt_gate), .cnt_out(cnt_out)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    cs_n = !sel; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic tick(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cnt_clk[idx] = 1'b1;
      repeat (4) @(negedge clk);
      cnt_clk[idx] = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic chk_out(input int idx, input logic e, input string tag);
    #1;
    check(cnt_out[idx] === e, tag, {15'd0, cnt_out[idx]}, {15'd0, e});
  endtask

  // monitor: pops the scoreboard for every selected read strobe
  always @(negedge clk) begin
    #2;
    if (!cs_n && !rd_n && addr != 2'd3) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", {8'd0, rdata}, 16'd0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(rdata === it.exp && rdata_oe === 1'b1, it.tag, {8'd0, rdata}, {8'd0, it.exp});
      end
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(cnt_out === 3'b111, "R1 outputs after reset", {13'd0, cnt_out}, 16'h0007);
    check(rdata_oe === 1'b0, "R1 bus idle after reset", {15'd0, rdata_oe}, 16'h0000);

    // R8 counter 0, terminal count, word format, binary
    bus_wr(2'd3, 8'h30, 1'b1);
    chk_out(0, 1'b0, "R8 out low after control write");
    bus_wr(2'd0, 8'h05, 1'b1);
    bus_wr(2'd0, 8'h00, 1'b1);
    tick(0, 1);
    bus_wr(2'd3, 8'h00, 1'b1);                 // R6 latch command
    bus_rd(2'd0, 8'h05, "R6 latched lo");
    bus_rd(2'd0, 8'h00, "R6 latched hi");
    tick(0, 4);
    chk_out(0, 1'b0, "R8 out low at count 1");
    bus_rd(2'd0, 8'h01, "R7 live lo");
    bus_rd(2'd0, 8'h00, "R7 live hi");
    tick(0, 1);
    chk_out(0, 1'b1, "R8 out high at zero");
    bus_rd(2'd0, 8'h00, "R8 zero lo");
    bus_rd(2'd0, 8'h00, "R8 zero hi");

    // R6 snapshot freeze and ignored second latch
    tick(0, 2);
    bus_wr(2'd3, 8'h00, 1'b1);
    tick(0, 3);
    bus_wr(2'd3, 8'h00, 1'b1);
    tick(0, 1);
    bus_rd(2'd0, 8'hFE, "R6 frozen lo");
    bus_rd(2'd0, 8'hFF, "R6 frozen hi");
    bus_rd(2'd0, 8'hFA, "R6 released live lo");
    bus_rd(2'd0, 8'hFF, "R6 released live hi");

    // R4 deselected accesses ignored, counting continues
    bus_wr(2'd3, 8'h34, 1'b0);
    bus_wr(2'd0, 8'h55, 1'b0);
    tick(0, 1);
    chk_out(0, 1'b1, "R4 out unchanged");
    bus_rd(2'd0, 8'hF9, "R4 still counting lo");
    bus_rd(2'd0, 8'hFF, "R4 still counting hi");

    // R3 control port read floats, counter port drives
    @(negedge clk);
    cs_n = 1'b0; addr = 2'd3; rd_n = 1'b0;
    #2;
    check(rdata_oe === 1'b0, "R3 control read undriven", {15'd0, rdata_oe}, 16'h0000);
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;

    // R9 counter 1 gate low pauses, LSB-only format
    cnt_gate[1] = 1'b0;
    bus_wr(2'd3, 8'h50, 1'b1);
    bus_wr(2'd1, 8'h03, 1'b1);
    tick(1, 3);
    bus_rd(2'd1, 8'h03, "R9 gate low holds count");
    chk_out(1, 1'b0, "R9 out still low");
    cnt_gate[1] = 1'b1;
    repeat (4) @(negedge clk);
    tick(1, 2);
    chk_out(1, 1'b0, "R8 counter1 at 1");
    tick(1, 1);
    chk_out(1, 1'b1, "R5 lsb-only reaches zero");
    bus_rd(2'd1, 8'h00, "R5 lsb-only read");

    // R13 independence
    tick(0, 5);
    bus_rd(2'd1, 8'h00, "R13 counter1 untouched");
    chk_out(1, 1'b1, "R13 out1 untouched");

    // R5 counter 2 MSB-only
    bus_wr(2'd3, 8'hA0, 1'b1);
    bus_wr(2'd2, 8'h02, 1'b1);
    tick(2, 1);
    bus_rd(2'd2, 8'h02, "R5 msb-only load");
    tick(2, 1);
    bus_rd(2'd2, 8'h01, "R5 msb-only after decrement");

    // R10 counter 2 rate generator, N = 3
    bus_wr(2'd3, 8'h94, 1'b1);
    chk_out(2, 1'b1, "R10 out high after control");
    bus_wr(2'd2, 8'h03, 1'b1);
    tick(2, 1);
    chk_out(2, 1'b1, "R10 high after load");
    tick(2, 1);
    chk_out(2, 1'b1, "R10 high at 2");
    tick(2, 1);
    chk_out(2, 1'b0, "R10 low at 1");
    tick(2, 1);
    chk_out(2, 1'b1, "R10 high after reload");
    tick(2, 2);
    chk_out(2, 1'b0, "R10 second pulse");
    tick(2, 1);
    chk_out(2, 1'b1, "R10 second reload");

    // R2 reserved selector ignored
    bus_wr(2'd3, 8'hF0, 1'b1);
    chk_out(2, 1'b1, "R2 selector 3 ignored");
    chk_out(0, 1'b1, "R2 counter0 unaffected");

    // R11 BCD
    bus_wr(2'd3, 8'h71, 1'b1);
    bus_wr(2'd1, 8'h00, 1'b1);
    bus_wr(2'd1, 8'h10, 1'b1);
    tick(1, 2);
    bus_rd(2'd1, 8'h99, "R11 bcd 1000-1 lo");
    bus_rd(2'd1, 8'h09, "R11 bcd 1000-1 hi");
    bus_wr(2'd3, 8'h71, 1'b1);
    bus_wr(2'd1, 8'h00, 1'b1);
    bus_wr(2'd1, 8'h00, 1'b1);
    tick(1, 2);
    bus_rd(2'd1, 8'h99, "R11 bcd zero lo");
    bus_rd(2'd1, 8'h99, "R11 bcd zero hi");

    // R12 binary zero
    bus_wr(2'd3, 8'h70, 1'b1);
    bus_wr(2'd1, 8'h00, 1'b1);
    bus_wr(2'd1, 8'h00, 1'b1);
    tick(1, 2);
    bus_rd(2'd1, 8'hFF, "R12 binary zero lo");
    bus_rd(2'd1, 8'hFF, "R12 binary zero hi");
    chk_out(1, 1'b0, "R12 out low while counting");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", 16'(sb_q.size()), 16'd0);
    done = 1'b1;
    report();
  end

endmodule